// File: doc/BRIEF.md
# Paged SRAM Write Guard and Eraser

This block sits between a bus master and a 32 KB single-port SRAM. The SRAM is treated as 32 pages of 1 KB each. A protection register holds one bit per page. Software can only set these bits, and only a system reset clears them. A memory write to a page whose bit is set never reaches the SRAM, and it raises a sticky error flag. Reads always pass through.

A wipe engine writes zero to every 32-bit word, one word per clock, from word 0 upwards. It can be started in two ways:
- Software sets the erase bit in the control register.
- The first clock after a system reset starts it when the erase-on-reset option input is high.

While the wipe runs, the engine owns the SRAM port. Master accesses are stalled: they are not granted and not forwarded.

The memory-side port uses 32-bit word addresses. Word address bits [12:8] select the page, which is the same as byte address bits [14:10]. The register port is combinational on read, and a register write takes effect at the clock edge where it is presented.

Top module: `sram_guard`

## Requirements
- R1: Word address w (byte offset 4*w) lies in page w/256, so page n spans byte offsets n*0x400 to n*0x400+0x3FF. Words 0x0FF and 0x100 fall in pages 0 and 1, and words 0x1FF and 0x200 fall in pages 1 and 2.
- R2: The protection register is at register address 0, with bit n belonging to page n. A write ORs the written data into the register, a zero data bit leaves a set bit unchanged, and a read returns the current bits.
- R3: A granted master write to a protected page drives ram_en and ram_we low. A master read of a protected page drives ram_en high with ram_we low. An access to an unprotected page is forwarded with its word address and data.
- R4: The control/status register is at register address 1. Its bit 2 becomes 1 in the cycle after a blocked write and stays 1 until a register write to address 1 with data bit 2 set. A blocked write in the same cycle as that clear wins, and the bit stays 1.
- R5: Writing 1 to control bit 0 while idle starts a wipe at that clock edge. Control bit 0 (erase request) and bit 1 (busy) both read 1 for the whole wipe, and both return to 0 when it completes.
- R6: During a wipe the SRAM port carries ram_en=1, ram_we=1 and ram_wdata=0. ram_addr counts from 0 by one per clock up to 8191, and busy lasts exactly 8192 cycles.
- R7: While a wipe runs, cpu_gnt is 0 and the master's address and data are not forwarded to the SRAM.
- R8: An erase request made while a wipe runs is ignored. The address keeps counting, and the total busy time stays 8192 cycles.
- R9: If opt_erase_on_reset is high, the first clock edge after reset release starts a wipe. If it is low, no wipe starts.
- R10: A wipe leaves the protection bits unchanged and writes zero into protected pages as well.
- R11: Only rst_n clears protection bits. After a reset every page is unprotected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| opt_erase_on_reset | input | 1 | Starts a wipe on the first clock after reset release |
| reg_sel | input | 1 | Register port select |
| reg_wr | input | 1 | Register write strobe (with reg_sel) |
| reg_addr | input | 1 | 0 = protection register, 1 = control/status register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| cpu_req | input | 1 | Master memory access request |
| cpu_we | input | 1 | Master access is a write |
| cpu_waddr | input | 13 | Master word address |
| cpu_wdata | input | 32 | Master write data |
| cpu_gnt | output | 1 | Request accepted (low while a wipe runs) |
| ram_en | output | 1 | SRAM enable |
| ram_we | output | 1 | SRAM write enable |
| ram_addr | output | 13 | SRAM word address |
| ram_wdata | output | 32 | SRAM write data |

## Verification
The hardest situation to reach is a second erase request that lands in the middle of a running wipe, together with master accesses against protected pages while the engine owns the port. Each wipe lasts thousands of cycles, so the bench holds the register port on the status address and counts busy cycles until the flag drops. Partway through that count it injects the repeat request and a stalled write. A behavioural model tracks the wipe counter, the protection bits and the error flag. The bench compares that model against every output on every cycle, so each of the 8192 wipe addresses is checked in order, and so is the boundary between adjacent pages.

// File: rtl/sg_pkg.sv
package sg_pkg;

  localparam int unsigned SG_PAGES_DEF      = 32;
  localparam int unsigned SG_PAGE_BYTES_DEF = 1024;
  localparam int unsigned SG_DATA_W_DEF     = 32;

  // control/status bit positions (software decodes these)
  localparam int unsigned CTL_ERASE = 0;
  localparam int unsigned CTL_BUSY  = 1;
  localparam int unsigned CTL_WERR  = 2;

  typedef enum logic {
    SEL_PROT = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;

  function automatic int unsigned words_per_page(int unsigned page_bytes,
                                                 int unsigned data_w);
    return page_bytes / (data_w / 8);
  endfunction

  function automatic int unsigned page_of_word(int unsigned waddr,
                                               int unsigned page_shift);
    return waddr >> page_shift;
  endfunction

endpackage

// File: rtl/sg_prot_reg.sv
module sg_prot_reg
  import sg_pkg::*;
#(
  parameter int unsigned PAGES = SG_PAGES_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic [PAGES-1:0] set_mask,
  output logic [PAGES-1:0] bits
);

  logic [PAGES-1:0] set_now;
  assign set_now = set_we ? set_mask : '0;

  // bits can only rise; reset is the sole way down
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits <= '0;
    else        bits <= bits | set_now;
  end

  AST_PROT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((bits & $past(set_mask)) == $past(set_mask))); // R2
  AST_PROT_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((bits & $past(bits)) == $past(bits))); // R11

endmodule

// File: rtl/sg_erase_engine.sv
module sg_erase_engine
  import sg_pkg::*;
#(
  parameter int unsigned WORDS = 8192,
  parameter int unsigned AW    = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] addr,
  output logic          last
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(WORDS - 1);

  assign last = busy && (addr == LAST_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      addr <= '0;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
        addr <= '0;
      end else begin
        addr <= addr + AW'(1);
      end
    end else if (start) begin
      busy <= 1'b1;
      addr <= '0;
    end
  end

  AST_ERASE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && addr == '0)); // R5
  AST_ERASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && addr == $past(addr) + AW'(1))); // R6
  AST_ERASE_END: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && addr != '0 && !last) |=> (addr != '0)); // R8

endmodule

// File: rtl/sg_access_gate.sv
module sg_access_gate
  import sg_pkg::*;
#(
  parameter int unsigned PAGES      = SG_PAGES_DEF,
  parameter int unsigned DATA_W     = SG_DATA_W_DEF,
  parameter int unsigned WORD_AW    = 13,
  parameter int unsigned PAGE_SHIFT = 8
) (
  input  logic               busy,
  input  logic [WORD_AW-1:0] erase_addr,
  input  logic [PAGES-1:0]   prot,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [WORD_AW-1:0] cpu_waddr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic               cpu_gnt,
  output logic               ram_en,
  output logic               ram_we,
  output logic [WORD_AW-1:0] ram_addr,
  output logic [DATA_W-1:0]  ram_wdata,
  output logic               wr_blocked
);

  localparam int unsigned PAGE_W = $clog2(PAGES);

  logic [PAGE_W-1:0] page;
  logic              page_locked;
  logic              cpu_go;

  assign page        = PAGE_W'(page_of_word(32'(cpu_waddr), PAGE_SHIFT));
  assign page_locked = prot[page];
  assign cpu_go      = cpu_req && !busy;
  assign cpu_gnt     = cpu_go;
  assign wr_blocked  = cpu_go && cpu_we && page_locked;

  always_comb begin
    if (busy) begin
      ram_en    = 1'b1;
      ram_we    = 1'b1;
      ram_addr  = erase_addr;
      ram_wdata = '0;
    end else begin
      ram_en    = cpu_go && !wr_blocked;
      ram_we    = cpu_go && cpu_we && !page_locked;
      ram_addr  = cpu_waddr;
      ram_wdata = cpu_wdata;
    end
  end

endmodule

// File: rtl/sram_guard.sv
module sram_guard
  import sg_pkg::*;
#(
  parameter int unsigned PAGES      = SG_PAGES_DEF,
  parameter int unsigned PAGE_BYTES = SG_PAGE_BYTES_DEF,
  parameter int unsigned DATA_W     = SG_DATA_W_DEF,
  localparam int unsigned PAGE_WORDS = words_per_page(PAGE_BYTES, DATA_W),
  localparam int unsigned WORDS      = PAGES * PAGE_WORDS,
  localparam int unsigned WORD_AW    = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               opt_erase_on_reset,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [WORD_AW-1:0] cpu_waddr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic               cpu_gnt,
  output logic               ram_en,
  output logic               ram_we,
  output logic [WORD_AW-1:0] ram_addr,
  output logic [DATA_W-1:0]  ram_wdata
);

  localparam int unsigned PAGE_SHIFT = $clog2(PAGE_WORDS);
  localparam int unsigned PAGE_W     = $clog2(PAGES);

  // named internal events
  logic               prot_wr;
  logic               ctrl_wr;
  logic               sw_erase;
  logic               err_clr;
  logic               boot_q;
  logic               boot_erase;
  logic               erase_start;
  logic               erase_busy;
  logic               erase_last;
  logic [WORD_AW-1:0] erase_addr;
  logic [PAGES-1:0]   prot_bits;
  logic               wr_blocked;
  logic               werr_q;

  assign prot_wr     = reg_sel && reg_wr && (reg_addr == SEL_PROT);
  assign ctrl_wr     = reg_sel && reg_wr && (reg_addr == SEL_CTRL);
  assign sw_erase    = ctrl_wr && reg_wdata[CTL_ERASE];
  assign err_clr     = ctrl_wr && reg_wdata[CTL_WERR];
  assign boot_erase  = boot_q && opt_erase_on_reset;
  assign erase_start = boot_erase || sw_erase;

  // one-cycle marker for the first edge after reset release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_q <= 1'b1;
    else        boot_q <= 1'b0;
  end

  sg_prot_reg #(.PAGES(PAGES)) u_prot (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_we   (prot_wr),
    .set_mask (reg_wdata[PAGES-1:0]),
    .bits     (prot_bits)
  );

  sg_erase_engine #(.WORDS(WORDS), .AW(WORD_AW)) u_wipe (
    .clk   (clk),
    .rst_n (rst_n),
    .start (erase_start),
    .busy  (erase_busy),
    .addr  (erase_addr),
    .last  (erase_last)
  );

  sg_access_gate #(
    .PAGES(PAGES), .DATA_W(DATA_W), .WORD_AW(WORD_AW), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_gate (
    .busy       (erase_busy),
    .erase_addr (erase_addr),
    .prot       (prot_bits),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_waddr  (cpu_waddr),
    .cpu_wdata  (cpu_wdata),
    .cpu_gnt    (cpu_gnt),
    .ram_en     (ram_en),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .wr_blocked (wr_blocked)
  );

  // sticky write error: a new block beats a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          werr_q <= 1'b0;
    else if (wr_blocked) werr_q <= 1'b1;
    else if (err_clr)    werr_q <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == SEL_PROT) begin
      reg_rdata[PAGES-1:0] = prot_bits;
    end else begin
      reg_rdata[CTL_ERASE] = erase_busy;
      reg_rdata[CTL_BUSY]  = erase_busy;
      reg_rdata[CTL_WERR]  = werr_q;
    end
  end

  AST_STALL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |-> (!cpu_gnt && ram_addr == erase_addr)); // R7
  AST_PROT_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && !erase_busy &&
     prot_bits[cpu_waddr[WORD_AW-1 -: PAGE_W]]) |-> (!ram_we && !ram_en)); // R3
  AST_WERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> werr_q); // R4
  AST_WERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (werr_q && !err_clr) |=> werr_q); // R4
  AST_BOOT_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_erase |=> erase_busy); // R9
  AST_WIPE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |-> (ram_en && ram_we && ram_wdata == '0)); // R10
  AST_WIPE_KEEPS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |=> ((prot_bits & $past(prot_bits)) == $past(prot_bits))); // R10

endmodule

// File: tb/sram_guard_test.sv
module sram_guard_test;

  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 8192;
  localparam int PG_WORDS   = 256;
  localparam int WATCHDOG   = 120000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opt = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [12:0] cpu_waddr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_gnt;
  logic        ram_en;
  logic        ram_we;
  logic [12:0] ram_addr;
  logic [31:0] ram_wdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_guard uut (
    .clk(clk), .rst_n(rst_n), .opt_erase_on_reset(opt),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_waddr(cpu_waddr),
    .cpu_wdata(cpu_wdata), .cpu_gnt(cpu_gnt),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_busy, m_err, m_boot;
  int          m_cnt;
  logic [31:0] m_prot;
  bit          m_start, m_blk;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_err = 0; m_boot = 1; m_cnt = 0; m_prot = '0;
    end else begin
      m_start = (m_boot && opt) || (reg_sel && reg_wr && reg_addr && reg_wdata[0]);
      m_blk   = !m_busy && cpu_req && cpu_we && m_prot[cpu_waddr / PG_WORDS];
      if (m_blk) m_err = 1;
      else if (reg_sel && reg_wr && reg_addr && reg_wdata[2]) m_err = 0;
      if (reg_sel && reg_wr && !reg_addr) m_prot = m_prot | reg_wdata;
      if (m_busy) begin
        if (m_cnt == WORDS - 1) begin m_busy = 0; m_cnt = 0; end
        else m_cnt++;
      end else if (m_start) begin
        m_busy = 1; m_cnt = 0;
      end
      m_boot = 0;
    end
  end

  // per-cycle comparison, away from the clock edges
  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      bit e_gnt, e_en, e_we, lk;
      logic [31:0] e_rd;
      lk    = m_prot[cpu_waddr / PG_WORDS];
      e_gnt = cpu_req && !m_busy;
      e_en  = m_busy || (cpu_req && (!cpu_we || !lk));
      e_we  = m_busy || (cpu_req && cpu_we && !lk);
      check(cpu_gnt === e_gnt, "R7 gnt", 32'(cpu_gnt), 32'(e_gnt));
      check(ram_en === e_en, "R3 ram_en", 32'(ram_en), 32'(e_en));
      check(ram_we === e_we, "R3 ram_we", 32'(ram_we), 32'(e_we));
      if (e_en) begin
        check(ram_addr === (m_busy ? 13'(m_cnt) : cpu_waddr), "R6 ram_addr",
              32'(ram_addr), m_busy ? 32'(m_cnt) : 32'(cpu_waddr));
        check(ram_wdata === (m_busy ? 32'd0 : cpu_wdata), "R6 ram_wdata",
              ram_wdata, m_busy ? 32'd0 : cpu_wdata);
      end
      e_rd = reg_addr ? {29'd0, m_err, m_busy, m_busy} : m_prot;
      check(reg_rdata === e_rd, reg_addr ? "R5 status" : "R2 prot", reg_rdata, e_rd);
    end
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG && !finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_reset(input bit o);
    @(negedge clk); rst_n = 1'b0; opt = o;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic reg_write(input bit a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input bit a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #2; d = reg_rdata;
  endtask

  task automatic cpu_op(input bit w, input logic [12:0] wa, input logic [31:0] d,
                        output bit en, output bit we);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = w; cpu_waddr = wa; cpu_wdata = d;
    #2; en = ram_en; we = ram_we;
    @(negedge clk); cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  // counts busy cycles from now; optionally injects a repeat request
  task automatic count_wipe(input int inject_at, output int n);
    n = 0;
    reg_addr = 1'b1;
    forever begin
      @(negedge clk);
      if (n == inject_at) begin
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h1;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_waddr = 13'h0400; cpu_wdata = 32'hDEAD_BEEF;
      end else begin
        reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0; cpu_req = 1'b0; cpu_we = 1'b0;
      end
      #2;
      if (n == inject_at)
        check(cpu_gnt === 1'b0 && ram_wdata === 32'd0, "R7 stall during wipe",
              32'(cpu_gnt), 32'd0);
      if (!reg_rdata[1]) break;
      n++;
    end
    reg_sel = 1'b0; reg_wr = 1'b0; cpu_req = 1'b0;
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    logic [31:0] rd;
    bit en, we;
    int n;

    do_reset(1'b0);
    repeat (3) @(negedge clk);
    reg_read(1'b1, rd);
    check(rd === 32'd0, "R9 no wipe without option", rd, 32'd0);
    reg_read(1'b0, rd);
    check(rd === 32'd0, "R11 reset state of protection", rd, 32'd0);

    reg_write(1'b0, 32'h0000_0005);
    reg_read(1'b0, rd);
    check(rd === 32'h5, "R2 set pages 0 and 2", rd, 32'h5);
    reg_write(1'b0, 32'h0);
    reg_read(1'b0, rd);
    check(rd === 32'h5, "R2 zero write keeps bits", rd, 32'h5);
    reg_write(1'b0, 32'h8000_0000);
    reg_read(1'b0, rd);
    check(rd === 32'h8000_0005, "R2 set page 31", rd, 32'h8000_0005);

    cpu_op(1'b1, 13'h0FF, 32'h1111_1111, en, we);
    check(!en && !we, "R1 last word of page 0 blocked", {31'd0, we}, 32'd0);
    cpu_op(1'b1, 13'h100, 32'h2222_2222, en, we);
    check(en && we, "R1 first word of page 1 written", {31'd0, we}, 32'd1);
    cpu_op(1'b1, 13'h1FF, 32'h3333_3333, en, we);
    check(en && we, "R1 last word of page 1 written", {31'd0, we}, 32'd1);
    cpu_op(1'b1, 13'h200, 32'h4444_4444, en, we);
    check(!en && !we, "R1 first word of page 2 blocked", {31'd0, we}, 32'd0);
    cpu_op(1'b0, 13'h1FFF, 32'h0, en, we);
    check(en && !we, "R3 read of protected page 31 passes", {30'd0, en, we}, 32'd2);

    reg_read(1'b1, rd);
    check(rd[2] === 1'b1, "R4 error flag set", rd, 32'h4);
    reg_write(1'b1, 32'h4);
    reg_read(1'b1, rd);
    check(rd[2] === 1'b0, "R4 error flag cleared", rd, 32'h0);

    // clear and block in the same cycle: block wins
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 32'h4;
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_waddr = 13'h0010;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0; cpu_req = 1'b0; cpu_we = 1'b0;
    #2;
    check(reg_rdata[2] === 1'b1, "R4 block beats clear", reg_rdata, 32'h4);
    reg_write(1'b1, 32'h4);

    // software wipe with a repeat request in the middle
    reg_write(1'b1, 32'h1);
    #2;
    check(reg_rdata[1:0] === 2'b11, "R5 request and busy read 1", reg_rdata, 32'h3);
    check(ram_we === 1'b1 && ram_addr === 13'd0, "R10 wipe writes protected page 0",
          32'(ram_addr), 32'd0);
    count_wipe(500, n);
    check(n == WORDS - 1, "R8 repeat request ignored, length kept", n, WORDS - 1);
    reg_read(1'b1, rd);
    check(rd[1:0] === 2'b00, "R5 request self-clears", rd, 32'h0);
    reg_read(1'b0, rd);
    check(rd === 32'h8000_0005, "R10 wipe keeps protection", rd, 32'h8000_0005);

    // plain wipe length
    reg_write(1'b1, 32'h1);
    count_wipe(-1, n);
    check(n == WORDS - 1, "R6 wipe length", n, WORDS - 1);

    // reset clears protection; option starts a wipe
    do_reset(1'b1);
    #2;
    reg_addr = 1'b1;
    #0;
    check(reg_rdata[1] === 1'b0, "R9 idle before first edge", reg_rdata, 32'h0);
    @(negedge clk); #2;
    check(reg_rdata[1] === 1'b1, "R9 wipe after reset release", reg_rdata, 32'h3);
    count_wipe(-1, n);
    check(n == WORDS - 1, "R9 boot wipe length", n, WORDS - 1);
    reg_read(1'b0, rd);
    check(rd === 32'd0, "R11 reset cleared protection", rd, 32'd0);
    cpu_op(1'b1, 13'h0FF, 32'h5555_5555, en, we);
    check(en && we, "R11 page 0 writable after reset", {31'd0, we}, 32'd1);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule